// File: doc/BRIEF.md
# Board Control Register File

A small memory-mapped register block for a development board. It sits behind a simple synchronous bus with separate read and write strobes, one 32-bit word per access, and decodes a 64 KiB window using the low sixteen address bits. Two of its words are fixed identification values: a build-date code and the processor clock frequency in hertz. A third word drives the board LEDs and can be read back. A fourth word reports the DIP switches, which are brought through a two-flop synchroniser before they reach the read path.

A fifth word is a control trigger. Writing the magic value 0x0000DEAD there raises a single-cycle board reset request. Any other value written there is discarded. The block only produces the request pulse. Distributing the reset to the rest of the board is the job of logic outside it. Read data is registered, so it appears one clock after the read strobe, and any offset without a register returns zero.

Top module: `board_ctrl_regs`

## Requirements
- R1: After reset, `leds_o` is 0, `rst_req_o` is 0 and `rd_data_o` is 0.
- R2: A read of offset 0x0000 returns 0x09272011 on `rd_data_o` in the cycle after the edge that samples `rd_en_i`. Writes to this offset leave the read value unchanged.
- R3: A read of offset 0x0004 returns 0x00989680 (10,000,000). Writes to this offset leave the read value unchanged.
- R4: A write to offset 0x0008 stores all 32 bits of `wr_data_i`. The stored value drives `leds_o` from the clock edge that accepts the write, and a read of 0x0008 returns it. Bit n set means LED n is on.
- R5: A read of offset 0x000C returns `sw_i` as it was sampled three clock edges before the read data appears: two synchroniser stages, then the read register. Bit n set means switch n is on. Writes to 0x000C have no effect on `leds_o` or on the read value.
- R6: A write of exactly 0x0000DEAD to offset 0x0010 makes `rst_req_o` high for exactly one cycle. The pulse is registered: it is high in the cycle after the edge that accepts the write.
- R7: A write of any other value to 0x0010 leaves `rst_req_o` low and does not change `leds_o`.
- R8: A read of any offset not listed above returns zero. Decoding uses address bits [15:0] only, so an address whose low 16 bits match a register offset selects that register.
- R9: While `rd_en_i` is low, `rd_data_o` holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| addr_i | input | 32 | Byte address of the word (bits [15:0] are decoded) |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| sw_i | input | 32 | Asynchronous DIP switch levels |
| leds_o | output | 32 | LED drive levels |
| rst_req_o | output | 1 | One-cycle board reset request |

## Verification
The assertions take for granted that the bus never raises the read and write strobes in the same cycle and that addresses are word aligned. The bench keeps to both by issuing one access at a time with aligned addresses.

The switch check assumes the switch inputs stay at one value for at least three edges before a read. The bench changes `sw_i` only between reads and then waits four cycles before reading.

The sweep covers every aligned offset in the first 64 bytes, with aliases above the window, and several values written to the trigger offset.

// File: rtl/board_ctrl_pkg.sv
// Package: shared offsets and constants for the board control registers.
// Assumes 32-bit word-aligned accesses.
package board_ctrl_pkg;
    localparam int unsigned DW          = 32;
    localparam int unsigned DEC_BITS    = 16;
    localparam logic [DW-1:0] BUILD_ID  = 32'h0927_2011;
    localparam logic [DW-1:0] CLK_HZ    = 32'd10_000_000;
    localparam logic [DW-1:0] RST_MAGIC = 32'h0000_DEAD;

    typedef enum logic [DEC_BITS-1:0] {
        OFS_ID   = 16'h0000,
        OFS_FREQ = 16'h0004,
        OFS_LED  = 16'h0008,
        OFS_SW   = 16'h000C,
        OFS_RST  = 16'h0010
    } reg_ofs_e;
endpackage

// File: rtl/bcr_sync.sv
// Module: two-flop synchroniser, one flop pair per bit.
// Assumes every bit of the input is an independent, slowly changing level.
module bcr_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two-stage capture of the asynchronous level.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/bcr_decode.sv
// Module: turns the low address bits into one-hot register selects.
// Assumes word-aligned addresses; bits above DEC_BITS are ignored.
module bcr_decode
    import board_ctrl_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] addr_i,
    output logic          sel_id_o,
    output logic          sel_freq_o,
    output logic          sel_led_o,
    output logic          sel_sw_o,
    output logic          sel_rst_o
);
    logic [DEC_BITS-1:0] ofs;

    // Keep only the window offset.
    assign ofs = addr_i[DEC_BITS-1:0];

    // Compare the offset with each register slot.
    always_comb begin
        sel_id_o   = (ofs == OFS_ID);
        sel_freq_o = (ofs == OFS_FREQ);
        sel_led_o  = (ofs == OFS_LED);
        sel_sw_o   = (ofs == OFS_SW);
        sel_rst_o  = (ofs == OFS_RST);
    end
endmodule

// File: rtl/board_ctrl_regs.sv
// Module: board control register file (top).
// Provides the identification words, the LED register, the synchronised
// switch read-back and the magic-value reset trigger.
// Assumes reads and writes never coincide; read data is registered.
module board_ctrl_regs
    import board_ctrl_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          rd_en_i,
    output logic [DW-1:0] rd_data_o,
    input  logic [DW-1:0] sw_i,
    output logic [DW-1:0] leds_o,
    output logic          rst_req_o
);
    logic          sel_id, sel_freq, sel_led, sel_sw, sel_rst;
    logic [DW-1:0] sw_sync;
    logic [DW-1:0] led_q;
    logic [DW-1:0] rd_q;
    logic          req_q;
    logic [DW-1:0] rd_mux;

    bcr_decode #(.AW(AW)) u_dec (
        .addr_i     (addr_i),
        .sel_id_o   (sel_id),
        .sel_freq_o (sel_freq),
        .sel_led_o  (sel_led),
        .sel_sw_o   (sel_sw),
        .sel_rst_o  (sel_rst)
    );

    bcr_sync #(.W(DW)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (sw_i),
        .q_o    (sw_sync)
    );

    // LED register: updated by a write to its own offset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                  led_q <= '0;
        else if (wr_en_i && sel_led)  led_q <= wr_data_i;
    end

    // Reset request: one-cycle pulse after a magic-value write.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) req_q <= 1'b0;
        else         req_q <= wr_en_i && sel_rst && (wr_data_i == RST_MAGIC);
    end

    // Read selection; unmapped offsets read as zero.
    always_comb begin
        rd_mux = '0;
        if (sel_id)   rd_mux = BUILD_ID;
        if (sel_freq) rd_mux = CLK_HZ;
        if (sel_led)  rd_mux = led_q;
        if (sel_sw)   rd_mux = sw_sync;
    end

    // Read data register: loads only on a read strobe.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)      rd_q <= '0;
        else if (rd_en_i) rd_q <= rd_mux;
    end

    assign rd_data_o = rd_q;
    assign leds_o    = led_q;
    assign rst_req_o = req_q;
endmodule

// File: rtl/board_ctrl_regs_chk.sv
// Module: property checker for board_ctrl_regs, attached by bind.
// Assumes the bus never raises the read and write strobes together.
module board_ctrl_regs_chk
    import board_ctrl_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic [AW-1:0] addr_i,
    input logic          wr_en_i,
    input logic [DW-1:0] wr_data_i,
    input logic          rd_en_i,
    input logic [DW-1:0] rd_data_o,
    input logic [DW-1:0] leds_o,
    input logic          rst_req_o
);
    logic [DEC_BITS-1:0] ofs;
    assign ofs = addr_i[DEC_BITS-1:0];

    // R6: a magic write to the trigger offset gives a pulse one cycle later.
    a_r6_magic_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && ofs == 16'h0010 && wr_data_i == 32'h0000DEAD) |=> rst_req_o);

    // R6: the pulse lasts a single cycle (trigger offset is not re-written).
    a_r6_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rst_req_o && !(wr_en_i && ofs == 16'h0010)) |=> !rst_req_o);

    // R7: any other value at the trigger offset gives no pulse.
    a_r7_other_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && ofs == 16'h0010 && wr_data_i != 32'h0000DEAD) |=> !rst_req_o);

    // R4: LEDs move only on a write to the LED offset.
    a_r4_led_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && ofs == 16'h0008) |=> $stable(leds_o));

    // R4: an LED write lands on the output next cycle.
    a_r4_led_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && ofs == 16'h0008) |=> (leds_o == $past(wr_data_i)));

    // R9: read data holds while no read strobe is seen.
    a_r9_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> $stable(rd_data_o));

    // R2: the build identifier reads back.
    a_r2_id_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && ofs == 16'h0000) |=> (rd_data_o == 32'h09272011));

    // R8: an unmapped offset reads zero.
    a_r8_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && ofs > 16'h0010) |=> (rd_data_o == '0));
endmodule

bind board_ctrl_regs board_ctrl_regs_chk #(.AW(AW)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_en_i   (rd_en_i),
    .rd_data_o (rd_data_o),
    .leds_o    (leds_o),
    .rst_req_o (rst_req_o)
);

// File: tb/board_ctrl_regs_tb.sv
// Bench for board_ctrl_regs: sweeps offsets and trigger values,
// computing each expected value from the requirements.
module board_ctrl_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic [31:0] sw = '0;
    logic [31:0] leds;
    logic        rst_req;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] led_model = '0;

    always #2 clk = ~clk;

    board_ctrl_regs u_dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .addr_i    (addr),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .rd_en_i   (rd_en),
        .rd_data_o (rd_data),
        .sw_i      (sw),
        .leds_o    (leds),
        .rst_req_o (rst_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one access at the falling edge so the next rising edge takes it.
    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    function automatic logic [31:0] expect_rd(input logic [15:0] o, input logic [31:0] s);
        case (o)
            16'h0000: return 32'h09272011;
            16'h0004: return 32'd10000000;
            16'h0008: return led_model;
            16'h000C: return s;
            default:  return 32'h0;
        endcase
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        logic        seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 leds", leds, 32'h0);
        check("R1 rst_req", {31'h0, rst_req}, 32'h0);
        check("R1 rd_data", rd_data, 32'h0);

        // R4: LED patterns.
        foreach (led_pat[i]) begin
            wr(32'h0000_0008, led_pat[i]);
            led_model = led_pat[i];
            check("R4 leds", leds, led_model);
            rd(32'h0000_0008, d);
            check("R4 readback", d, led_model);
        end

        // R2 R3 R5: writes to fixed and switch offsets are ignored.
        sw = 32'hA5A5_0F0F;
        repeat (4) @(negedge clk);
        wr(32'h0, 32'hFFFF_FFFF);
        wr(32'h4, 32'h1234_5678);
        wr(32'hC, 32'h0);
        check("R5 leds untouched", leds, led_model);
        rd(32'h0, d); check("R2 id", d, 32'h09272011);
        rd(32'h4, d); check("R3 freq", d, 32'd10000000);
        rd(32'hC, d); check("R5 switches", d, 32'hA5A5_0F0F);

        // R5: switch patterns, settled before each read.
        for (int k = 0; k < 32; k++) begin
            sw = 32'h1 << k;
            repeat (4) @(negedge clk);
            rd(32'hC, d);
            check("R5 sw walk", d, 32'h1 << k);
        end

        // R8: sweep offsets 0..0x3C and aliases above the window.
        for (int o = 0; o < 64; o += 4) begin
            rd(o, d);
            check("R8 sweep", d, expect_rd(o[15:0], sw));
            rd(32'h0003_0000 + o, d);
            check("R8 alias", d, expect_rd(o[15:0], sw));
        end
        rd(32'h0000_FFFC, d); check("R8 top", d, 32'h0);

        // R9: read data holds without a read strobe.
        rd(32'h0, d);
        @(negedge clk); addr = 32'h4;
        repeat (3) @(negedge clk);
        check("R9 hold", rd_data, 32'h09272011);

        // R6: magic write pulses for exactly one cycle.
        @(negedge clk);
        addr = 32'h10; wr_data = 32'h0000DEAD; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        check("R6 pulse high", {31'h0, rst_req}, 32'h1);
        @(negedge clk);
        check("R6 pulse low", {31'h0, rst_req}, 32'h0);
        check("R6 leds kept", leds, led_model);

        // R7: other values give no pulse.
        foreach (bad_pat[i]) begin
            seen = 1'b0;
            @(negedge clk);
            addr = 32'h10; wr_data = bad_pat[i]; wr_en = 1'b1;
            @(negedge clk); wr_en = 1'b0; seen |= rst_req;
            @(negedge clk); seen |= rst_req;
            check("R7 no pulse", {31'h0, seen}, 32'h0);
            check("R7 leds kept", leds, led_model);
        end

        // R6: magic aliased above the window still triggers.
        @(negedge clk);
        addr = 32'h0001_0010; wr_data = 32'h0000DEAD; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        check("R6 alias pulse", {31'h0, rst_req}, 32'h1);

        // R1: reset again clears the LEDs.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 re-reset leds", leds, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    logic [31:0] led_pat [4] = '{32'hFFFF_FFFF, 32'h0000_0001, 32'h8000_0000, 32'h5A5A_C3C3};
    logic [31:0] bad_pat [5] = '{32'h0, 32'h0000DEAC, 32'h0000DEAF, 32'h0001DEAD, 32'hDEAD_0000};
endmodule